// File: doc/BRIEF.md
# Host Register Interface with Data Request

This block is the processor-facing register file of a disk controller. A host selects it with an active-low chip select. It reads or writes one of four register slots through a 2-bit address, using active-low read and write strobes. The 8-bit bidirectional bus is split into an input byte, an output byte and an output enable. The block holds the command, track, sector and data registers, and builds the status byte from core-supplied flags plus its own lost-data and data-request bits.

On the disk side the block trades whole bytes with a serial shift register through single-cycle strobes. The direction is chosen by the controller core. When the disk is being read, each incoming byte lands in the data register and raises the data request (DRQ). When the disk is being written, each byte the shift register takes raises DRQ so the host can supply the next one. If the host falls behind in either direction, a lost-data flag is set and an interrupt is raised. On a write underrun a zero byte goes out in place of the missing data.

The strobes are sampled on the clock. An access takes effect once, in the cycle in which its strobe is first seen low while the chip is selected.

Top module: `host_regfile`

## Requirements
- R1: An active-high synchronous reset clears the data, track, sector and command registers, DRQ, the lost-data flag and the interrupt request.
- R2: Address 1 reads and writes the track register, address 2 the sector register and address 3 the data register. Address 0 reads the status byte and writes the command register.
- R3: The output enable is high only while chip select and read enable are both low.
- R4: Each access acts once, on the first sampled low of its strobe while chip select is low. Holding the strobe low does not repeat the access.
- R5: In disk-read direction (dir_wr low), an rx_strobe loads rx_byte into the data register and sets DRQ. A host read of the data register clears DRQ.
- R6: In disk-read direction, an rx_strobe while DRQ is still set and the data register is not being read in that cycle sets the lost-data flag (status bit 2) and raises the interrupt.
- R7: In disk-write direction (dir_wr high), tx_byte shows the host-loaded data register during a tx_strobe, and DRQ is set afterwards. A host write of the data register clears DRQ.
- R8: In disk-write direction, a tx_strobe when the data register has not been reloaded since the last transfer or command shows tx_byte = 0, and it sets the lost-data flag and the interrupt.
- R9: Status bit 1 shows DRQ while xfer_active is high and core_stat[1] otherwise. Bit 2 is the lost-data flag. Bits 7..3 and bit 0 come from core_stat.
- R10: A host read of the status register clears the interrupt. A write to the command register clears the interrupt, DRQ, the lost-data flag and the reloaded state.
- R11: An op_done pulse raises the interrupt, and the interrupt stays set until it is cleared.
- R12: A command write drives the written byte on cmd_byte, with cmd_pulse high for exactly the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| re_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register slot |
| din | input | 8 | Host bus, incoming byte |
| dout | output | 8 | Host bus, outgoing byte |
| dout_en | output | 1 | Host bus drive enable |
| dir_wr | input | 1 | Transfer direction, 1 = toward disk |
| xfer_active | input | 1 | Data transfer in progress (DRQ shown in status) |
| rx_strobe | input | 1 | Assembled byte ready from shift register |
| rx_byte | input | 8 | Assembled byte |
| tx_strobe | input | 1 | Shift register takes the next byte |
| tx_byte | output | 8 | Byte handed to shift register |
| op_done | input | 1 | Operation finished (normal or abnormal) |
| core_stat | input | 8 | Core-owned status flags |
| drq | output | 1 | Data request |
| irq | output | 1 | Interrupt request |
| cmd_pulse | output | 1 | New command written |
| cmd_byte | output | 8 | Last command byte |
| track | output | 8 | Track register |
| sector | output | 8 | Sector register |

## Verification
The hardest case is a strobe held low across several clock cycles while another event arrives in the middle. A status read that is held low must clear the interrupt only once, so an op_done that comes during the hold must leave the interrupt set. The stimulus keeps chip select and read enable low for four cycles and pulses op_done in the second cycle. Back-to-back rx_strobe pulses with no read in between produce the overrun case. A second tx_strobe with no data write in between produces the zero-byte underrun case.

// File: rtl/host_regfile.sv
module host_regfile #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          re_n,
  input  logic          we_n,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  input  logic          dir_wr,
  input  logic          xfer_active,
  input  logic          rx_strobe,
  input  logic [DW-1:0] rx_byte,
  input  logic          tx_strobe,
  output logic [DW-1:0] tx_byte,
  input  logic          op_done,
  input  logic [DW-1:0] core_stat,
  output logic          drq,
  output logic          irq,
  output logic          cmd_pulse,
  output logic [DW-1:0] cmd_byte,
  output logic [DW-1:0] track,
  output logic [DW-1:0] sector
);
  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_TRK  = 2'd1;
  localparam logic [1:0] A_SEC  = 2'd2;
  localparam logic [1:0] A_DATA = 2'd3;

  logic          re_q, we_q;
  logic          lost, full;
  logic [DW-1:0] data_q, status;

  always_ff @(posedge clk) begin
    if (rst) begin
      re_q <= 1'b1;
      we_q <= 1'b1;
    end else begin
      re_q <= re_n;
      we_q <= we_n;
    end
  end

  wire rd_ev    = !cs_n && re_q && !re_n;
  wire wr_ev    = !cs_n && we_q && !we_n;
  wire rd_stat  = rd_ev && addr == A_STAT;
  wire rd_data  = rd_ev && addr == A_DATA;
  wire wr_cmd   = wr_ev && addr == A_STAT;
  wire wr_data  = wr_ev && addr == A_DATA;
  wire rx_ev    = rx_strobe && !dir_wr;
  wire tx_ev    = tx_strobe && dir_wr;
  wire overrun  = rx_ev && drq && !rd_data;
  wire underrun = tx_ev && !full;
  wire lost_ev  = overrun || underrun;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      track  <= '0;
      sector <= '0;
    end else begin
      if (rx_ev)                          data_q <= rx_byte;
      else if (wr_data)                   data_q <= din;
      if (wr_ev && addr == A_TRK)         track  <= din;
      if (wr_ev && addr == A_SEC)         sector <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_byte  <= '0;
      cmd_pulse <= 1'b0;
    end else begin
      cmd_pulse <= wr_cmd;
      if (wr_cmd) cmd_byte <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || wr_cmd)               full <= 1'b0;
    else if (wr_data)                full <= 1'b1;
    else if (tx_ev)                  full <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || wr_cmd)               drq <= 1'b0;
    else if (rx_ev)                  drq <= 1'b1;
    else if (rd_data && !dir_wr)     drq <= 1'b0;
    else if (wr_data && dir_wr)      drq <= 1'b0;
    else if (tx_ev)                  drq <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || wr_cmd)               lost <= 1'b0;
    else if (lost_ev)                lost <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                         irq <= 1'b0;
    else if (op_done || lost_ev)     irq <= 1'b1;
    else if (rd_stat || wr_cmd)      irq <= 1'b0;
  end

  assign status  = {core_stat[DW-1:3], lost, xfer_active ? drq : core_stat[1], core_stat[0]};
  assign dout_en = !cs_n && !re_n;
  assign tx_byte = full ? data_q : '0;

  always_comb begin
    case (addr)
      A_STAT:  dout = status;
      A_TRK:   dout = track;
      A_SEC:   dout = sector;
      default: dout = data_q;
    endcase
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!drq && !irq && !lost && !cmd_pulse && track == '0 && sector == '0));

  a_r5_rx_sets_drq: assert property (@(posedge clk) disable iff (rst)
    (rx_ev && !wr_cmd) |=> (drq && data_q == $past(rx_byte)));

  a_r6_overrun_flags: assert property (@(posedge clk) disable iff (rst)
    (rx_ev && drq && !rd_data && !wr_cmd) |=> (lost && irq));

  a_r8_underrun_flags: assert property (@(posedge clk) disable iff (rst)
    (tx_ev && !full && !wr_cmd) |=> (lost && irq));

  a_r10_cmd_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && !op_done && !lost_ev) |=> (!irq && !drq && !lost));

  a_r11_done_irq: assert property (@(posedge clk) disable iff (rst)
    op_done |=> irq);

  a_r12_cmd_strobe: assert property (@(posedge clk) disable iff (rst)
    wr_cmd |=> (cmd_pulse && cmd_byte == $past(din)));
endmodule

// File: tb/tb_host_regfile.sv
`timescale 1ns/100ps
module tb_host_regfile;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, re_n = 1'b1, we_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic       dout_en;
  logic       dir_wr = 1'b0, xfer_active = 1'b0;
  logic       rx_strobe = 1'b0, tx_strobe = 1'b0, op_done = 1'b0;
  logic [7:0] rx_byte = 8'h00, core_stat = 8'h00;
  logic [7:0] tx_byte, cmd_byte, track, sector;
  logic       drq, irq, cmd_pulse;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic mon_arm = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  host_regfile dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .re_n(re_n), .we_n(we_n), .addr(addr),
    .din(din), .dout(dout), .dout_en(dout_en), .dir_wr(dir_wr),
    .xfer_active(xfer_active), .rx_strobe(rx_strobe), .rx_byte(rx_byte),
    .tx_strobe(tx_strobe), .tx_byte(tx_byte), .op_done(op_done),
    .core_stat(core_stat), .drq(drq), .irq(irq), .cmd_pulse(cmd_pulse),
    .cmd_byte(cmd_byte), .track(track), .sector(sector)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  always @(posedge clk) begin
    if (mon_arm) begin
      #1;
      if (exp_q.size() > 0) begin
        check({tag_q.pop_front(), " read"}, dout, exp_q.pop_front());
        check("R3 read enable", {7'd0, dout_en}, 8'd1);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic host_read(input logic [1:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    cs_n = 1'b0; re_n = 1'b0; addr = a; mon_arm = 1'b1;
    tick();
    cs_n = 1'b1; re_n = 1'b1; mon_arm = 1'b0;
    tick();
  endtask

  task automatic host_write(input logic [1:0] a, input logic [7:0] d);
    cs_n = 1'b0; we_n = 1'b0; addr = a; din = d;
    tick();
    cs_n = 1'b1; we_n = 1'b1;
    tick();
  endtask

  task automatic pulse_rx(input logic [7:0] b);
    rx_strobe = 1'b1; rx_byte = b;
    tick();
    rx_strobe = 1'b0;
    tick();
  endtask

  task automatic pulse_tx(input logic [7:0] exp, input string tag);
    tx_strobe = 1'b1;
    #1 check(tag, tx_byte, exp);
    tick();
    tx_strobe = 1'b0;
    tick();
  endtask

  task automatic pulse_done();
    op_done = 1'b1;
    tick();
    op_done = 1'b0;
    tick();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    check("R1 drq", {7'd0, drq}, 8'd0);
    check("R1 irq", {7'd0, irq}, 8'd0);
    host_read(2'd0, 8'h00, "R1 status");
    host_read(2'd1, 8'h00, "R1 track");
    host_read(2'd2, 8'h00, "R1 sector");
    host_read(2'd3, 8'h00, "R1 data");

    // R2 register map
    host_write(2'd1, 8'h5A);
    host_write(2'd2, 8'h3C);
    host_write(2'd3, 8'h99);
    host_read(2'd1, 8'h5A, "R2 track");
    host_read(2'd2, 8'h3C, "R2 sector");
    host_read(2'd3, 8'h99, "R2 data");
    check("R2 track port", track, 8'h5A);

    // R3 bus drive enable
    cs_n = 1'b1; re_n = 1'b0; #1 check("R3 cs high", {7'd0, dout_en}, 8'd0);
    cs_n = 1'b0; re_n = 1'b1; #1 check("R3 re high", {7'd0, dout_en}, 8'd0);
    cs_n = 1'b1; tick();

    // R12 command strobe
    cs_n = 1'b0; we_n = 1'b0; addr = 2'd0; din = 8'h8C;
    tick();
    cs_n = 1'b1; we_n = 1'b1;
    check("R12 pulse", {7'd0, cmd_pulse}, 8'd1);
    check("R12 byte", cmd_byte, 8'h8C);
    tick();
    check("R12 pulse width", {7'd0, cmd_pulse}, 8'd0);

    // R5 disk-read transfer
    xfer_active = 1'b1;
    pulse_rx(8'hA5);
    check("R5 drq set", {7'd0, drq}, 8'd1);
    host_read(2'd0, 8'h02, "R5 R9 status drq");
    host_read(2'd3, 8'hA5, "R5 data");
    check("R5 drq cleared", {7'd0, drq}, 8'd0);

    // R6 overrun
    pulse_rx(8'hA1);
    pulse_rx(8'hA2);
    check("R6 irq", {7'd0, irq}, 8'd1);
    host_read(2'd0, 8'h06, "R6 status lost");
    check("R10 status read clears irq", {7'd0, irq}, 8'd0);
    host_read(2'd3, 8'hA2, "R6 latest data");

    // R11 completion, R10 command clear
    pulse_done();
    check("R11 irq", {7'd0, irq}, 8'd1);
    host_write(2'd0, 8'h10);
    check("R10 cmd clears irq", {7'd0, irq}, 8'd0);
    host_read(2'd0, 8'h00, "R10 lost cleared");

    // R4 held strobe acts once
    pulse_done();
    exp_q.push_back(8'h00); tag_q.push_back("R4 held status");
    cs_n = 1'b0; re_n = 1'b0; addr = 2'd0; mon_arm = 1'b1;
    tick();
    mon_arm = 1'b0;
    op_done = 1'b1;
    tick();
    op_done = 1'b0;
    tick();
    tick();
    cs_n = 1'b1; re_n = 1'b1;
    tick();
    check("R4 irq survives hold", {7'd0, irq}, 8'd1);

    // R7 disk-write transfer
    dir_wr = 1'b1;
    host_write(2'd0, 8'hA0);
    host_write(2'd3, 8'h3C);
    pulse_tx(8'h3C, "R7 tx first");
    check("R7 drq set", {7'd0, drq}, 8'd1);
    host_write(2'd3, 8'h7E);
    check("R7 drq cleared", {7'd0, drq}, 8'd0);
    pulse_tx(8'h7E, "R7 tx second");
    check("R7 no lost irq", {7'd0, irq}, 8'd0);

    // R8 underrun
    pulse_tx(8'h00, "R8 zero byte");
    check("R8 irq", {7'd0, irq}, 8'd1);
    host_read(2'd0, 8'h06, "R8 status lost");

    // R9 status composition
    core_stat = 8'hA3;
    xfer_active = 1'b0;
    host_read(2'd0, 8'hA7, "R9 core bit1");
    xfer_active = 1'b1;
    host_read(2'd0, 8'hA7, "R9 drq bit1 set");
    host_write(2'd0, 8'h00);
    host_read(2'd0, 8'hA1, "R9 drq bit1 clear");
    xfer_active = 1'b0;
    host_read(2'd0, 8'hA3, "R9 core bit1 again");

    repeat (3) tick();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule